// File: doc/BRIEF.md
# Reset Clock Source Sequencer

This block decides which oscillator drives each branch of a microcontroller clock tree, from reset release until software takes over. The branches are the CPU clock, a group of peripheral clocks and a low-power display/timer clock.

At every reset the CPU and peripheral branches fall back to the ring oscillator. A hardware counter then holds the CPU clock invalid until the ring oscillator has had time to settle. Firmware starts the main oscillator with an enable level and a programmable settle count. When that count expires, every peripheral branch moves to the main oscillator on the same edge, and a status flag reports that main-derived clocks are live.

Software can turn on the PLL and the spread-spectrum generator, and it can choose the CPU and slow-clock sources, through a small write port. The block rejects any request that would use a source that is not yet available and records it in a sticky error flag. Only a cold reset cause returns the slow-clock choice to the ring oscillator; warm resets keep it.

Top module: `clk_src_seq`

## Requirements
- R1: While reset is held and on release, cpu_src and periph_src are ring (code 00), pll_on, sscg_on, cfg_err and main_stable are low.
- R2: cpu_clk_valid rises exactly RING_STAB_CYC+1 rising edges after the first edge sampled with rst_n high, and stays high until the next reset.
- R3: With load value L on main_stab_load, main_stable rises exactly L+1 edges after the first edge at which main_osc_en is sampled high. It is low one edge after main_osc_en is sampled low.
- R4: periph_src changes from ring (00) to main (01), and main_clk_active rises, one edge after main_stable rises. Both return to ring/low one edge after main_stable is low.
- R5: Reset cause codes are 3 bits: 001 power-on clear, 010 external pin, 011 watchdog, 100 software, any other value "other". During reset, slow_src is forced to ring only for codes 001 and 010. For every other code it keeps its value.
- R6: A write to address 00 (bit 0 = PLL enable, bit 1 = spread-spectrum enable) with non-zero data while main_stable is low is ignored and sets cfg_err. While main_stable is high, the data is loaded into pll_on and sscg_on.
- R7: cfg_err, once set, stays high until the next reset of any cause, and is low after it.
- R8: Source codes are ring 00, main 01, sub 10, PLL 11. A write to address 01 sets cpu_src and a write to address 10 sets slow_src, but only if the requested source is available. Ring and sub are always available. Main is available while main_stable is high. PLL is available for cpu_src while pll_on and main_stable are both high, and never for slow_src. A rejected write leaves the select unchanged and sets cfg_err.
- R9: If the source held in cpu_src or slow_src becomes unavailable, that select returns to ring on the next edge. pll_on and sscg_on clear on the edge after main_stable is low.
- R10: A write to address 11 changes no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rst_cause | input | 3 | Reset cause code, valid while rst_n is low |
| main_osc_en | input | 1 | Firmware enable for the main oscillator |
| main_stab_load | input | MAIN_CW | Main oscillator settle count, loaded when enabled |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration write address |
| cfg_wdata | input | 2 | Configuration write data |
| cpu_src | output | 2 | CPU clock source select |
| cpu_clk_valid | output | 1 | Ring oscillator settle time has elapsed |
| periph_src | output | 2 | Peripheral clock group source select |
| slow_src | output | 2 | Display/watch-timer clock source select |
| main_stable | output | 1 | Main oscillator settle count expired |
| main_clk_active | output | 1 | Peripheral clocks are running from the main oscillator |
| pll_on | output | 1 | PLL enable |
| sscg_on | output | 1 | Spread-spectrum generator enable |
| cfg_err | output | 1 | Sticky flag for rejected writes |

## Verification
A settle counter that is off by one shows up as main_stable or cpu_clk_valid moving one edge early or late. The bench therefore samples every edge across a sweep of load values, so such a fault appears at the first wrong edge. A stale peripheral edge register shows up as periph_src lagging or ignoring a drop of the main oscillator within two edges. A bad availability or cause decode shows up on cpu_src, slow_src and cfg_err on the edge right after the offending write or reset. The bench sweeps every select value under three availability states and every reset cause code.

// File: rtl/clk_src_pkg.sv
// Shared source and reset-cause codes plus availability helpers for the
// reset clock source sequencer. Assumes 2-bit source codes.
package clk_src_pkg;

    typedef enum logic [1:0] {
        SRC_RING = 2'b00,
        SRC_MAIN = 2'b01,
        SRC_SUB  = 2'b10,
        SRC_PLL  = 2'b11
    } clk_src_e;

    localparam logic [2:0] CAUSE_POC = 3'b001;
    localparam logic [2:0] CAUSE_PIN = 3'b010;
    localparam logic [2:0] CAUSE_WDT = 3'b011;
    localparam logic [2:0] CAUSE_SW  = 3'b100;

    localparam logic [1:0] ADDR_GEN  = 2'b00;
    localparam logic [1:0] ADDR_CPU  = 2'b01;
    localparam logic [1:0] ADDR_SLOW = 2'b10;

    // Cold causes wipe the retained slow-clock choice.
    function automatic logic cold_cause(input logic [2:0] c);
        return (c == CAUSE_POC) || (c == CAUSE_PIN);
    endfunction

    // True when the given source may currently be selected.
    function automatic logic src_ok(input clk_src_e s, input logic main_ok,
                                    input logic pll_ok);
        case (s)
            SRC_RING, SRC_SUB: return 1'b1;
            SRC_MAIN:          return main_ok;
            default:           return pll_ok;
        endcase
    endfunction

endpackage

// File: rtl/osc_stab_cnt.sv
// Oscillator settle timer. When en is first sampled high the counter is
// armed and loaded with `load`; it then counts down once per edge and
// stable is high while armed and at zero. Dropping en disarms it.
// Assumes load is held steady around the arming edge.
module osc_stab_cnt #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] load,
    output logic          stable
);

    logic [CW-1:0] cnt_q;
    logic          armed_q;

    // Arm-and-load on enable, then count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (!en) begin
            cnt_q   <= '0;
            armed_q <= 1'b0;
        end else if (!armed_q) begin
            cnt_q   <= load;
            armed_q <= 1'b1;
        end else if (cnt_q != '0) begin
            cnt_q   <= cnt_q - 1'b1;
        end
    end

    // Settled once armed and the count has run out.
    always_comb stable = armed_q && (cnt_q == '0);

    // R3
    off_drops_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !stable);

    // R3
    rise_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stable) |-> $past(en));

endmodule

// File: rtl/periph_switch.sv
// Moves the peripheral clock group from ring to main oscillator on the
// rising edge of main_stable, all selects at once, and back to ring when
// main_stable falls. Assumes main_stable is synchronous to clk.
module periph_switch (
    input  logic clk,
    input  logic rst_n,
    input  logic main_stable,
    output logic on_main
);

    logic stable_q;

    // Edge-detect main_stable and hold the switched state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stable_q <= 1'b0;
            on_main  <= 1'b0;
        end else begin
            stable_q <= main_stable;
            if (!main_stable)
                on_main <= 1'b0;
            else if (!stable_q)
                on_main <= 1'b1;
        end
    end

    // R4
    switch_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_stable) |=> on_main);

    // R4
    back_to_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !main_stable |=> !on_main);

endmodule

// File: rtl/slow_sel_keep.sv
// Retained display/watch-timer source select. Only cold reset causes put it
// back to ring; warm resets keep it. Writes of an unavailable source are
// flagged through bad_wr. Assumes rst_cause is valid while rst_n is low.
module slow_sel_keep
    import clk_src_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] rst_cause,
    input  logic       wr_en,
    input  logic [1:0] wdata,
    input  logic       main_stable,
    output clk_src_e   slow_sel,
    output logic       bad_wr
);

    // PLL is never a legal slow-clock source.
    always_comb bad_wr = wr_en && !src_ok(clk_src_e'(wdata), main_stable, 1'b0);

    // Cause-dependent reset, guarded write, fallback on loss of source.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            if (cold_cause(rst_cause))
                slow_sel <= SRC_RING;
        end else if (wr_en && !bad_wr) begin
            slow_sel <= clk_src_e'(wdata);
        end else if (!src_ok(slow_sel, main_stable, 1'b0)) begin
            slow_sel <= SRC_RING;
        end
    end

    // R5
    cold_reset_ring_chk: assert property (@(posedge clk)
        (!rst_n && cold_cause(rst_cause)) |=> (slow_sel == SRC_RING));

    // R5
    warm_reset_keep_chk: assert property (@(posedge clk)
        (!rst_n && !cold_cause(rst_cause) && $past(!rst_n)) |=> $stable(slow_sel));

endmodule

// File: rtl/cfg_regs.sv
// Software-facing enables and CPU source select. Enables for the PLL and
// spread-spectrum generator need a stable main oscillator; CPU source
// writes need an available source. Rejects set a sticky error.
// Assumes one write per cycle on a single strobe.
module cfg_regs
    import clk_src_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_wr,
    input  logic [1:0] cfg_addr,
    input  logic [1:0] cfg_wdata,
    input  logic       main_stable,
    input  logic       slow_bad,
    output logic       pll_on,
    output logic       sscg_on,
    output clk_src_e   cpu_sel,
    output logic       cfg_err
);

    logic gen_wr, gen_bad, cpu_wr, cpu_bad, pll_ok;

    // Decode writes and judge them against current availability.
    always_comb begin
        pll_ok  = pll_on && main_stable;
        gen_wr  = cfg_wr && (cfg_addr == ADDR_GEN);
        gen_bad = gen_wr && (cfg_wdata != 2'b00) && !main_stable;
        cpu_wr  = cfg_wr && (cfg_addr == ADDR_CPU);
        cpu_bad = cpu_wr && !src_ok(clk_src_e'(cfg_wdata), main_stable, pll_ok);
    end

    // PLL / spread-spectrum enables, dropped whenever main is not stable.
    always_ff @(posedge clk) begin
        if (!rst_n || !main_stable) begin
            pll_on  <= 1'b0;
            sscg_on <= 1'b0;
        end else if (gen_wr) begin
            pll_on  <= cfg_wdata[0];
            sscg_on <= cfg_wdata[1];
        end
    end

    // CPU source: guarded write, fallback to ring on loss of source.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cpu_sel <= SRC_RING;
        else if (cpu_wr && !cpu_bad)
            cpu_sel <= clk_src_e'(cfg_wdata);
        else if (!src_ok(cpu_sel, main_stable, pll_ok))
            cpu_sel <= SRC_RING;
    end

    // Sticky record of any rejected write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_err <= 1'b0;
        else if (gen_bad || cpu_bad || slow_bad)
            cfg_err <= 1'b1;
    end

    // R6
    early_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_addr == ADDR_GEN && cfg_wdata != 2'b00 && !main_stable)
        |=> (!pll_on && !sscg_on && cfg_err));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    // R9
    pll_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !main_stable |=> (!pll_on && !sscg_on));

    // R8
    cpu_no_main_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !main_stable |=> (cpu_sel != SRC_MAIN && cpu_sel != SRC_PLL));

endmodule

// File: rtl/clk_src_seq.sv
// Reset clock source sequencer top. Ties together the ring and main
// settle timers, the peripheral auto-switch, the software registers and
// the retained slow-clock select. Assumes all inputs are synchronous to clk.
module clk_src_seq
    import clk_src_pkg::*;
#(
    parameter int RING_STAB_CYC = 16,
    parameter int MAIN_CW       = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2:0]         rst_cause,
    input  logic               main_osc_en,
    input  logic [MAIN_CW-1:0] main_stab_load,
    input  logic               cfg_wr,
    input  logic [1:0]         cfg_addr,
    input  logic [1:0]         cfg_wdata,
    output logic [1:0]         cpu_src,
    output logic               cpu_clk_valid,
    output logic [1:0]         periph_src,
    output logic [1:0]         slow_src,
    output logic               main_stable,
    output logic               main_clk_active,
    output logic               pll_on,
    output logic               sscg_on,
    output logic               cfg_err
);

    localparam int RING_CW = $clog2(RING_STAB_CYC + 1);
    localparam logic [RING_CW-1:0] RING_LOAD = RING_CW'(RING_STAB_CYC);

    logic     on_main, slow_bad;
    clk_src_e cpu_sel, slow_sel;

    osc_stab_cnt #(.CW(RING_CW)) ring_tmr_i (
        .clk(clk), .rst_n(rst_n), .en(1'b1), .load(RING_LOAD),
        .stable(cpu_clk_valid)
    );

    osc_stab_cnt #(.CW(MAIN_CW)) main_tmr_i (
        .clk(clk), .rst_n(rst_n), .en(main_osc_en), .load(main_stab_load),
        .stable(main_stable)
    );

    periph_switch psw_i (
        .clk(clk), .rst_n(rst_n), .main_stable(main_stable), .on_main(on_main)
    );

    slow_sel_keep slow_i (
        .clk(clk), .rst_n(rst_n), .rst_cause(rst_cause),
        .wr_en(cfg_wr && (cfg_addr == ADDR_SLOW)), .wdata(cfg_wdata),
        .main_stable(main_stable), .slow_sel(slow_sel), .bad_wr(slow_bad)
    );

    cfg_regs regs_i (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .main_stable(main_stable), .slow_bad(slow_bad),
        .pll_on(pll_on), .sscg_on(sscg_on), .cpu_sel(cpu_sel), .cfg_err(cfg_err)
    );

    // Drive the source-select ports from internal state.
    always_comb begin
        cpu_src         = cpu_sel;
        slow_src        = slow_sel;
        periph_src      = on_main ? SRC_MAIN : SRC_RING;
        main_clk_active = on_main;
    end

    // R2
    valid_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_valid |=> cpu_clk_valid);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (cpu_src == SRC_RING && periph_src == SRC_RING &&
                    !pll_on && !sscg_on && !cfg_err && !main_stable));

endmodule

// File: tb/clk_src_seq_tb_top.sv
module clk_src_seq_tb_top;

    localparam int RING = 5;
    localparam int MCW  = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [2:0]     rst_cause = 3'b001;
    logic           main_osc_en = 1'b0;
    logic [MCW-1:0] main_stab_load = '0;
    logic           cfg_wr = 1'b0;
    logic [1:0]     cfg_addr = 2'b00;
    logic [1:0]     cfg_wdata = 2'b00;
    logic [1:0]     cpu_src, periph_src, slow_src;
    logic           cpu_clk_valid, main_stable, main_clk_active;
    logic           pll_on, sscg_on, cfg_err;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    clk_src_seq #(.RING_STAB_CYC(RING), .MAIN_CW(MCW)) dut_i (
        .clk(clk), .rst_n(rst_n), .rst_cause(rst_cause),
        .main_osc_en(main_osc_en), .main_stab_load(main_stab_load),
        .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cpu_src(cpu_src), .cpu_clk_valid(cpu_clk_valid),
        .periph_src(periph_src), .slow_src(slow_src),
        .main_stable(main_stable), .main_clk_active(main_clk_active),
        .pll_on(pll_on), .sscg_on(sscg_on), .cfg_err(cfg_err)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset(input logic [2:0] cause);
        @(negedge clk);
        rst_n = 1'b0;
        rst_cause = cause;
        step(3);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [1:0] d);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic main_up();
        main_osc_en = 1'b1;
        main_stab_load = 3'd2;
        step(5);
    endtask

    function automatic logic avail(input int s, input logic m, input logic p);
        if (s == 0 || s == 2) return 1'b1;
        if (s == 1) return m;
        return p && m;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main_seq
        logic [1:0] exp_cpu, exp_slow;
        logic       exp_err;

        // R1 / R2: cold reset, then ring settle timing edge by edge
        step(1);
        step(3);
        chk("R1 cpu_src in reset", cpu_src, 0);
        chk("R1 periph_src in reset", periph_src, 0);
        chk("R1 cfg_err in reset", cfg_err, 0);
        chk("R5 slow_src after power-on", slow_src, 0);
        rst_n = 1'b1;
        for (int n = 1; n <= RING + 3; n++) begin
            step(1);
            chk("R2 cpu_clk_valid timing", cpu_clk_valid, (n >= RING + 1) ? 1 : 0);
        end
        chk("R1 pll_on", pll_on, 0);
        chk("R1 main_stable", main_stable, 0);

        // R3 / R4: sweep main settle counts
        for (int l = 0; l < (1 << MCW); l++) begin
            main_stab_load = MCW'(l);
            @(negedge clk);
            main_osc_en = 1'b1;
            for (int n = 1; n <= l + 3; n++) begin
                step(1);
                chk("R3 main_stable rise", main_stable, (n >= l + 1) ? 1 : 0);
                chk("R4 periph_src", periph_src, (n >= l + 2) ? 1 : 0);
                chk("R4 main_clk_active", main_clk_active, (n >= l + 2) ? 1 : 0);
            end
            main_osc_en = 1'b0;
            step(1);
            chk("R3 main_stable drop", main_stable, 0);
            step(1);
            chk("R4 periph back to ring", periph_src, 0);
            chk("R4 main_clk_active drop", main_clk_active, 0);
        end

        // R6: enable writes with main off
        for (int d = 0; d < 4; d++) begin
            wr(2'b00, 2'(d));
            chk("R6 pll ignored", pll_on, 0);
            chk("R6 sscg ignored", sscg_on, 0);
            chk("R6 err set", cfg_err, (d != 0) ? 1 : 0);
        end
        step(10);
        chk("R7 err sticky", cfg_err, 1);
        wr(2'b10, 2'b10);
        do_reset(3'b100);
        step(1);
        chk("R7 err cleared by reset", cfg_err, 0);

        // R6: enable writes with main stable
        main_up();
        for (int d = 0; d < 4; d++) begin
            wr(2'b00, 2'(d));
            chk("R6 pll loaded", pll_on, d & 1);
            chk("R6 sscg loaded", sscg_on, (d >> 1) & 1);
            chk("R6 no err", cfg_err, 0);
        end

        // R8: CPU select sweep under three availability states
        for (int sc = 0; sc < 3; sc++) begin
            main_osc_en = 1'b0;
            do_reset(3'b100);
            if (sc > 0) main_up();
            if (sc == 2) wr(2'b00, 2'b01);
            exp_cpu = 2'b00;
            exp_err = 1'b0;
            for (int v = 0; v < 4; v++) begin
                wr(2'b01, 2'(v));
                if (avail(v, sc > 0, sc == 2)) exp_cpu = 2'(v);
                else exp_err = 1'b1;
                chk("R8 cpu_src", cpu_src, exp_cpu);
                chk("R8 cfg_err", cfg_err, exp_err);
            end
        end

        // R9: PLL selected, then main dropped
        wr(2'b01, 2'b11);
        chk("R8 cpu on pll", cpu_src, 3);
        main_osc_en = 1'b0;
        step(2);
        chk("R9 cpu back to ring", cpu_src, 0);
        chk("R9 pll cleared", pll_on, 0);
        chk("R9 periph back to ring", periph_src, 0);

        // R8 / R9: slow select rules
        main_osc_en = 1'b0;
        do_reset(3'b100);
        exp_slow = slow_src;
        wr(2'b10, 2'b01);
        chk("R8 slow main rejected", slow_src, exp_slow);
        chk("R8 slow reject err", cfg_err, 1);
        main_up();
        wr(2'b10, 2'b11);
        chk("R8 slow pll rejected", slow_src, exp_slow);
        wr(2'b10, 2'b01);
        chk("R8 slow main accepted", slow_src, 1);
        main_osc_en = 1'b0;
        step(2);
        chk("R9 slow back to ring", slow_src, 0);

        // R10: address 11 is inert
        main_up();
        wr(2'b00, 2'b11);
        wr(2'b01, 2'b01);
        wr(2'b11, 2'b10);
        chk("R10 cpu_src", cpu_src, 1);
        chk("R10 pll_on", pll_on, 1);
        chk("R10 sscg_on", sscg_on, 1);
        chk("R10 slow_src", slow_src, 0);
        chk("R10 cfg_err", cfg_err, 1);
        main_osc_en = 1'b0;

        // R5: every cause code against a retained sub selection
        for (int c = 0; c < 8; c++) begin
            wr(2'b10, 2'b10);
            chk("R5 slow set to sub", slow_src, 2);
            do_reset(3'(c));
            step(1);
            chk("R5 slow after reset", slow_src, (c == 1 || c == 2) ? 0 : 2);
            chk("R1 cpu after reset", cpu_src, 0);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule